// File: doc/BRIEF.md
# Dual-Lane Unsigned Word Divider

This block divides two pairs of 32-bit unsigned integers at the same time. Each 64-bit operand carries a high element and a low element. The block divides each dividend element by the divisor element in the same position and packs the two 32-bit quotients into one 64-bit result. No remainder is returned.

A lane whose divisor is zero does not iterate. It reports the saturated quotient 0xFFFFFFFF and raises that lane's overflow flag. The block keeps two sets of status bits. The overflow flags describe only the most recent operation. The sticky flags collect every overflow since they were last cleared. Both lanes run a restoring shift-subtract loop in lockstep, so an operation always takes the same number of cycles, whatever the operands.

A caller pulses `start_i` with both operands while the block is idle. It then waits for the single-cycle `done_o` pulse, and at that point the quotient and the flags are ready.

Top module: `dual_word_divider`

## Requirements
- R1: The high lane uses bits [63:32] of `dividend_i` and `divisor_i`, and its quotient is placed in `quotient_o[63:32]`. The low lane uses bits [31:0] of both operands and writes `quotient_o[31:0]`.
- R2: For a nonzero divisor, each lane's quotient is the unsigned integer quotient rounded toward zero, computed independently of the other lane.
- R3: A zero divisor in a lane yields 0xFFFFFFFF in that lane's quotient field and has no effect on the other lane's result.
- R4: `ovf_o[1]` is the high-lane overflow and `ovf_o[0]` is the low-lane overflow. Both bits go to 0 on the edge that accepts a start. When `done_o` rises, each bit is set to 1 exactly when its own lane's divisor was zero.
- R5: `sticky_o[1]` (high lane) and `sticky_o[0]` (low lane) are OR-accumulated with the overflow of each completed operation. They never drop to 0 unless `sticky_clr_i` is asserted.
- R6: A cycle with `sticky_clr_i` high clears both sticky bits on the next edge. If an operation completes on that same edge, its overflow is still recorded in the sticky bits. The clear does not touch `ovf_o`.
- R7: `done_o` is a one-cycle pulse that appears exactly 33 clock edges after the edge that accepted `start_i`. `busy_o` is high from acceptance until `done_o` rises. `quotient_o` holds its value until the next completion.
- R8: `start_i` is ignored while `busy_o` is high. The running operation completes with its original operands.
- R9: After reset, `busy_o`, `done_o`, `quotient_o`, `ovf_o` and `sticky_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| dividend_i | input | 64 | Packed dividends: high lane [63:32], low lane [31:0] |
| divisor_i | input | 64 | Packed divisors: high lane [63:32], low lane [31:0] |
| sticky_clr_i | input | 1 | Synchronous clear of both sticky bits |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 64 | Packed quotients, same lane layout as the operands |
| ovf_o | output | 2 | Overflow of the last operation: [1] high lane, [0] low lane |
| sticky_o | output | 2 | Accumulated overflow: [1] high lane, [0] low lane |

## Verification
The bench drives a zero divisor in one lane only, then in the other, then in both. A design that shares the zero detection between lanes, or swaps the flag bits, shows up as a corrupted neighbour quotient or as a flag in the wrong bit. It also exercises all-ones operands, a dividend smaller than its divisor, and equal operands. These cases catch a restoring step that loses the carry bit or ends one iteration early or late. It raises a sticky clear on the same edge that an operation finishes, and it raises a second start in the middle of a run. A design that gives the clear priority over new overflow, or restarts on a busy start, returns wrong flags or a quotient of the second operands.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
  typedef enum logic [1:0] {
    DWD_IDLE = 2'd0,
    DWD_RUN  = 2'd1,
    DWD_FIN  = 2'd2
  } dwd_state_e;
endpackage

// File: rtl/dwd_ctrl.sv
module dwd_ctrl
  import dwd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  dwd_state_e state_q;
  logic [CW-1:0] cnt_q;

  assign load_o = start_i && (state_q == DWD_IDLE);
  assign step_o = (state_q == DWD_RUN);
  assign fin_o  = (state_q == DWD_FIN);
  assign busy_o = (state_q != DWD_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DWD_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        DWD_IDLE: if (start_i) begin
          state_q <= DWD_RUN;
          cnt_q   <= '0;
        end
        DWD_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= DWD_FIN;
        end
        DWD_FIN: state_q <= DWD_IDLE;
        default: state_q <= DWD_IDLE;
      endcase
    end
  end

  // R7
  fin_after_last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> ($past(step_o) && ($past(cnt_q) == LAST)));

  // R8
  no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !load_o);
endmodule

// File: rtl/dwd_lane.sv
module dwd_lane #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic         dz_o
);
  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic         dz_q;
  logic [2*W-1:0] next_pair;

  // One restoring iteration: shift in the next dividend bit, subtract if it fits.
  function automatic logic [2*W-1:0] restore_step(input logic [W-1:0] rem,
                                                  input logic [W-1:0] quo,
                                                  input logic [W-1:0] dvs);
    logic [W:0] shifted;
    logic [W:0] diff;
    shifted = {rem, quo[W-1]};
    diff    = shifted - {1'b0, dvs};
    if (shifted >= {1'b0, dvs}) return {diff[W-1:0], quo[W-2:0], 1'b1};
    else                        return {shifted[W-1:0], quo[W-2:0], 1'b0};
  endfunction

  assign next_pair = restore_step(rem_q, quo_q, dvs_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      dz_q  <= 1'b0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= dvd_i;
      dvs_q <= dvs_i;
      dz_q  <= (dvs_i == '0);
    end else if (step_i && !dz_q) begin
      {rem_q, quo_q} <= next_pair;
    end
  end

  assign quo_o = dz_q ? '1 : quo_q;
  assign dz_o  = dz_q;

  // R2
  rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_i) && !dz_q) |-> (rem_q < dvs_q));

  // R3
  zero_lane_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dz_q && step_i) |=> (quo_o == '1));
endmodule

// File: rtl/dwd_status.sv
module dwd_status #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             fin_i,
  input  logic [LANES-1:0] dz_i,
  input  logic             sticky_clr_i,
  output logic [LANES-1:0] ovf_o,
  output logic [LANES-1:0] sticky_o
);
  logic [LANES-1:0] new_ovf;

  assign new_ovf = fin_i ? dz_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_o    <= '0;
      sticky_o <= '0;
    end else begin
      if (load_i)     ovf_o <= '0;
      else if (fin_i) ovf_o <= dz_i;
      sticky_o <= (sticky_clr_i ? '0 : sticky_o) | new_ovf;
    end
  end

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_clr_i |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

  // R6
  clear_keeps_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr_i && fin_i) |=> (sticky_o == ovf_o));
endmodule

// File: rtl/dual_word_divider.sv
module dual_word_divider #(
  parameter int LANE_W = 32,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [LANES*LANE_W-1:0] dividend_i,
  input  logic [LANES*LANE_W-1:0] divisor_i,
  input  logic                    sticky_clr_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [LANES*LANE_W-1:0] quotient_o,
  output logic [LANES-1:0]        ovf_o,
  output logic [LANES-1:0]        sticky_o
);
  localparam int TW = LANES * LANE_W;
  localparam int LW = $clog2(LANE_W + 2) + 1;
  localparam logic [LW-1:0] LATENCY = LW'(LANE_W + 1);

  logic          load_w, step_w, fin_w;
  logic [TW-1:0] lane_flat;
  logic [LANES-1:0] lane_dz;

  dwd_ctrl #(.W(LANE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load_w), .step_o(step_w), .fin_o(fin_w), .busy_o(busy_o)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dwd_lane #(.W(LANE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(step_w),
      .dvd_i(dividend_i[i*LANE_W +: LANE_W]),
      .dvs_i(divisor_i[i*LANE_W +: LANE_W]),
      .quo_o(lane_flat[i*LANE_W +: LANE_W]),
      .dz_o(lane_dz[i])
    );

    // R3
    sat_when_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ovf_o[i]) |-> (quotient_o[i*LANE_W +: LANE_W] == '1));
  end

  dwd_status #(.LANES(LANES)) u_status (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .fin_i(fin_w),
    .dz_i(lane_dz), .sticky_clr_i(sticky_clr_i),
    .ovf_o(ovf_o), .sticky_o(sticky_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      quotient_o <= '0;
    end else begin
      done_o <= fin_w;
      if (fin_w) quotient_o <= lane_flat;
    end
  end

  // Latency watch for the assertions below.
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (load_w) lat_q <= '0;
    else if (busy_o) lat_q <= lat_q + 1'b1;
  end

  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_q == LATENCY));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  busy_ends_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (ovf_o == '0));

  // R5
  ovf_in_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((ovf_o & ~sticky_o) == '0));
endmodule

// File: tb/sim_dual_word_divider.sv
module sim_dual_word_divider;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] dividend_i = '0;
  logic [63:0] divisor_i = '0;
  logic        sticky_clr_i = 1'b0;
  logic        busy_o, done_o;
  logic [63:0] quotient_o;
  logic [1:0]  ovf_o, sticky_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [1:0] exp_sticky = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_word_divider u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .sticky_clr_i(sticky_clr_i), .busy_o(busy_o), .done_o(done_o),
    .quotient_o(quotient_o), .ovf_o(ovf_o), .sticky_o(sticky_o)
  );

  function automatic logic [31:0] ref_div(input logic [31:0] n, input logic [31:0] d);
    if (d == 32'd0) return 32'hFFFF_FFFF;
    return n / d;
  endfunction

  function automatic logic [63:0] ref_pair(input logic [63:0] a, input logic [63:0] b);
    return {ref_div(a[63:32], b[63:32]), ref_div(a[31:0], b[31:0])};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input bit clr_at_done, input bit poke_busy);
    int k;
    logic [1:0] exp_ov;
    logic [63:0] held;
    exp_ov = {b[63:32] == 32'd0, b[31:0] == 32'd0};
    @(negedge clk);
    dividend_i = a; divisor_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R7 busy after accept", {63'd0, busy_o}, 64'd1);
    check("R4 ovf cleared at accept", {62'd0, ovf_o}, 64'd0);
    k = 0;
    for (int c = 1; c <= 40 && k == 0; c++) begin
      if (poke_busy && c == 5) begin
        start_i = 1'b1; dividend_i = ~a; divisor_i = 64'h0000_0003_0000_0005;
      end
      if (clr_at_done && c == 33) sticky_clr_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; sticky_clr_i = 1'b0;
      if (done_o) k = c;
    end
    check("R7 latency", 64'(k), 64'd33);
    check("R1 R2 R3 quotient", quotient_o, ref_pair(a, b));
    check("R4 ovf flags", {62'd0, ovf_o}, {62'd0, exp_ov});
    check("R7 busy low at done", {63'd0, busy_o}, 64'd0);
    exp_sticky = clr_at_done ? exp_ov : (exp_sticky | exp_ov);
    check(clr_at_done ? "R6 sticky clear at done" : "R5 sticky", {62'd0, sticky_o}, {62'd0, exp_sticky});
    held = quotient_o;
    @(negedge clk);
    check("R7 done one cycle", {63'd0, done_o}, 64'd0);
    check("R7 quotient held", quotient_o, held);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [63:0] a, b;
    void'($urandom(32'h0d1e_5eed));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy", {63'd0, busy_o}, 64'd0);
    check("R9 done", {63'd0, done_o}, 64'd0);
    check("R9 quotient", quotient_o, 64'd0);
    check("R9 ovf", {62'd0, ovf_o}, 64'd0);
    check("R9 sticky", {62'd0, sticky_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 distinct lanes
    run_op({32'd100, 32'hFFFF_FFFF}, {32'd7, 32'd1}, 0, 0);
    run_op({32'd3, 32'd50}, {32'd9, 32'd50}, 0, 0);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0002, 0, 0);
    run_op({32'd0, 32'h8000_0001}, {32'd5, 32'h8000_0000}, 0, 0);
    // R3 zero divisor high only, then low only, then both
    run_op({32'd1234, 32'd99}, {32'd0, 32'd4}, 0, 0);
    run_op({32'd77, 32'd0}, {32'd11, 32'd0}, 0, 0);
    // R6 idle clear
    @(negedge clk); sticky_clr_i = 1'b1;
    @(negedge clk); sticky_clr_i = 1'b0;
    exp_sticky = 2'b00;
    check("R6 idle clear sticky", {62'd0, sticky_o}, 64'd0);
    check("R6 idle clear keeps ovf", {62'd0, ovf_o}, 64'd1);
    run_op(64'd5, 64'd0, 0, 0);
    // R6 clear on the completion edge keeps new overflow
    run_op({32'd8, 32'd8}, {32'd0, 32'd2}, 1, 0);
    // R8 start while busy
    run_op({32'd1000, 32'd999}, {32'd10, 32'd3}, 0, 1);
    run_op({32'd1000, 32'd999}, {32'd10, 32'd0}, 0, 1);

    // random mix
    for (int n = 0; n < 40; n++) begin
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      if (($urandom() % 4) == 0) b[63:32] = $urandom() % 16;
      if (($urandom() % 4) == 0) b[31:0] = $urandom() % 16;
      if (($urandom() % 8) == 0) b[63:32] = 32'd0;
      if (($urandom() % 8) == 0) b[31:0] = 32'd0;
      run_op(a, b, ($urandom() % 10) == 0, ($urandom() % 6) == 0);
    end
    finish_run();
  end
endmodule